// File: doc/BRIEF.md
# Minimal 16-bit Single-Cycle Processor

This block is a tiny processor core that completes one instruction on every rising clock edge. It holds a 10-bit program counter and eight 16-bit general registers. It has two separate memories of 1024 words each, one for the program and one for data. The instruction set has five members: a register add, a relative branch taken when register 0 is zero, a load from data memory, a store to data memory, and a set-immediate.

The surrounding system fills the memories while the core is held in synchronous reset. The program memory has its own write port. The data memory has a load port, which is honoured only during reset; once the core runs, the data memory belongs to the store instruction.

A debug side lets a test or monitor observe the core. It can select any register or any data-memory word and read it back one cycle later, and it can watch the program counter directly. Register 0 is an ordinary writable register.

Top module: `tiny16_cpu`

## Requirements
- R1: While `rst` is high, the program counter is zero and all eight registers are cleared to zero. The debug register port returns 0 for every register during reset.
- R2: An instruction word carries the opcode in bits 15..13 and register fields A, B and C in bits 12..10, 9..7 and 6..4. Opcode 000 writes reg[A] + reg[B] into reg[C], modulo 65536, and then advances the PC by one.
- R3: Opcode 001 uses bits 9..0 as an unsigned offset. If reg[0] is zero, the PC becomes PC + offset modulo 1024. Otherwise the PC advances by one. No register changes in either case.
- R4: Opcode 010 copies the data-memory word addressed by bits 9..0 into reg[A] and advances the PC by one.
- R5: Opcode 011 writes reg[A] into the data-memory word addressed by bits 9..0 and advances the PC by one.
- R6: Opcode 100 writes bits 9..0, zero-extended to 16 bits, into reg[A] and advances the PC by one.
- R7: Opcodes 101, 110 and 111 change no register and no memory word. They only advance the PC by one.
- R8: The data-memory load port writes only while `rst` is high. Outside reset, a load-port write leaves the addressed word unchanged.
- R9: The debug register and data-memory outputs show the selected item one clock edge after the select is presented, so a new select leaves the output unchanged until that edge. `pc` shows the program counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, also the memory-load window |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 10 | Program memory write address |
| prog_data | input | 16 | Program memory write data |
| data_we | input | 1 | Data memory load-port write enable (effective in reset only) |
| data_addr | input | 10 | Data memory load-port address |
| data_wdata | input | 16 | Data memory load-port write data |
| dbg_reg_sel | input | 3 | Register selected for debug readback |
| dbg_reg_val | output | 16 | Registered value of the selected register |
| dbg_mem_addr | input | 10 | Data-memory word selected for debug readback |
| dbg_mem_val | output | 16 | Registered value of the selected data word |
| pc | output | 10 | Current program counter |

## Verification
The add is driven with operands loaded from data memory whose sum overflows 16 bits, and with a small sum. Together these separate a wrapping adder from a carrying or truncating one, and a correct destination field from a swapped one. The branch is stepped one cycle at a time through a not-taken case with reg[0] nonzero, a taken forward jump, and a taken jump whose target passes address 1023. This pins down both the zero test and the 10-bit wrap. The unused opcodes are given words with every field bit set, so that any stray register or memory write would land on a location the bench then reads back. Load-port writes are issued while the core runs to confirm they are blocked.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 3'b000,
    OPC_BR  = 3'b001,
    OPC_LD  = 3'b010,
    OPC_ST  = 3'b011,
    OPC_SET = 3'b100
  } opc_e;

endpackage

// File: rtl/tiny16_ram.sv
module tiny16_ram #(
  parameter int DW      = 16,
  parameter int AW      = 10,
  parameter bit SYNC_RD = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // combinational port feeds the single-cycle datapath
  assign rdata_a = mem[raddr_a];

  generate
    if (SYNC_RD) begin : g_sync_rd
      // registered port: returns the pre-write contents on a same-cycle write
      always_ff @(posedge clk) begin
        rdata_b <= mem[raddr_b];
      end
    end else begin : g_no_rd
      logic unused_raddr_b;
      assign unused_raddr_b = ^raddr_b;
      assign rdata_b = '0;
    end
  endgenerate

endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] rd_a_addr,
  output logic [DW-1:0]  rd_a_data,
  input  logic [RAW-1:0] rd_b_addr,
  output logic [DW-1:0]  rd_b_data,
  output logic [DW-1:0]  zero_data,
  input  logic [RAW-1:0] dbg_addr,
  output logic [DW-1:0]  dbg_data
);

  localparam int NREG = 2 ** RAW;

  logic [NREG-1:0][DW-1:0] regs;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs[g] <= '0;
        end else if (we && (waddr == RAW'(g))) begin
          regs[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rd_a_data = regs[rd_a_addr];
  assign rd_b_data = regs[rd_b_addr];
  assign zero_data = regs[0];

  always_ff @(posedge clk) begin
    dbg_data <= regs[dbg_addr];
  end

  // ---------------- assertions ----------------
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reg_clear_r1: assert (regs == '0)
        else $error("register file not cleared after reset");
    end
  end

  // R2/R4/R6: a granted write lands in the addressed register
  p_reg_update_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)));

  // R3/R5/R7: without a write the whole file holds
  p_reg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs));

endmodule

// File: rtl/tiny16_exec.sv
module tiny16_exec
  import tiny16_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 10,
  parameter int RAW = 3
) (
  input  logic [DW-1:0]  instr,
  input  logic [AW-1:0]  pc,
  input  logic [DW-1:0]  a_data,
  input  logic [DW-1:0]  b_data,
  input  logic [DW-1:0]  zero_data,
  input  logic [DW-1:0]  dm_rdata,
  output opc_e           op,
  output logic [RAW-1:0] sel_a,
  output logic [RAW-1:0] sel_b,
  output logic [AW-1:0]  next_pc,
  output logic           reg_we,
  output logic [RAW-1:0] reg_waddr,
  output logic [DW-1:0]  reg_wdata,
  output logic           dm_we,
  output logic [AW-1:0]  dm_addr,
  output logic [DW-1:0]  dm_wdata
);

  localparam int OP_LSB = DW - OPC_W;
  localparam int RA_LSB = OP_LSB - RAW;
  localparam int RB_LSB = RA_LSB - RAW;
  localparam int RC_LSB = RB_LSB - RAW;

  logic [RAW-1:0] fld_a;
  logic [RAW-1:0] fld_b;
  logic [RAW-1:0] fld_c;
  logic [AW-1:0]  fld_imm;
  logic [DW-1:0]  sum;
  logic [AW-1:0]  pc_inc;
  logic [AW-1:0]  pc_jump;
  logic           r0_is_zero;

  assign op      = opc_e'(instr[DW-1 -: OPC_W]);
  assign fld_a   = instr[RA_LSB +: RAW];
  assign fld_b   = instr[RB_LSB +: RAW];
  assign fld_c   = instr[RC_LSB +: RAW];
  assign fld_imm = instr[AW-1:0];

  assign sel_a = fld_a;
  assign sel_b = fld_b;

  // all arithmetic wraps at its own width
  assign sum        = a_data + b_data;
  assign pc_inc     = pc + AW'(1);
  assign pc_jump    = pc + fld_imm;
  assign r0_is_zero = (zero_data == '0);

  assign dm_addr  = fld_imm;
  assign dm_wdata = a_data;

  always_comb begin
    next_pc   = pc_inc;
    reg_we    = 1'b0;
    reg_waddr = fld_a;
    reg_wdata = sum;
    dm_we     = 1'b0;
    unique case (op)
      OPC_ADD: begin
        reg_we    = 1'b1;
        reg_waddr = fld_c;
        reg_wdata = sum;
      end
      OPC_BR: begin
        if (r0_is_zero) begin
          next_pc = pc_jump;
        end
      end
      OPC_LD: begin
        reg_we    = 1'b1;
        reg_wdata = dm_rdata;
      end
      OPC_ST: begin
        dm_we = 1'b1;
      end
      OPC_SET: begin
        reg_we    = 1'b1;
        reg_wdata = DW'(fld_imm);
      end
      default: begin
        next_pc = pc_inc;
      end
    endcase
  end

endmodule

// File: rtl/tiny16_cpu.sv
module tiny16_cpu
  import tiny16_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 10,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_we,
  input  logic [AW-1:0]  prog_addr,
  input  logic [DW-1:0]  prog_data,
  input  logic           data_we,
  input  logic [AW-1:0]  data_addr,
  input  logic [DW-1:0]  data_wdata,
  input  logic [RAW-1:0] dbg_reg_sel,
  output logic [DW-1:0]  dbg_reg_val,
  input  logic [AW-1:0]  dbg_mem_addr,
  output logic [DW-1:0]  dbg_mem_val,
  output logic [AW-1:0]  pc
);

  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  instr;
  logic [DW-1:0]  unused_pm_rd;

  opc_e           op;
  logic [RAW-1:0] sel_a;
  logic [RAW-1:0] sel_b;
  logic [DW-1:0]  a_data;
  logic [DW-1:0]  b_data;
  logic [DW-1:0]  zero_data;
  logic [AW-1:0]  next_pc;
  logic           ex_reg_we;
  logic [RAW-1:0] ex_reg_waddr;
  logic [DW-1:0]  ex_reg_wdata;
  logic           ex_dm_we;
  logic [AW-1:0]  ex_dm_addr;
  logic [DW-1:0]  ex_dm_wdata;
  logic [DW-1:0]  dm_rdata;

  logic           dm_we;
  logic [AW-1:0]  dm_waddr;
  logic [DW-1:0]  dm_wdata;

  // program memory: written only from the load port
  tiny16_ram #(.DW(DW), .AW(AW), .SYNC_RD(1'b0)) i_pmem (
    .clk     (clk),
    .we      (prog_we),
    .waddr   (prog_addr),
    .wdata   (prog_data),
    .raddr_a (pc_q),
    .rdata_a (instr),
    .raddr_b (pc_q),
    .rdata_b (unused_pm_rd)
  );

  // reset window belongs to the load port, run time to the store path
  assign dm_we    = rst ? data_we    : ex_dm_we;
  assign dm_waddr = rst ? data_addr  : ex_dm_addr;
  assign dm_wdata = rst ? data_wdata : ex_dm_wdata;

  tiny16_ram #(.DW(DW), .AW(AW), .SYNC_RD(1'b1)) i_dmem (
    .clk     (clk),
    .we      (dm_we),
    .waddr   (dm_waddr),
    .wdata   (dm_wdata),
    .raddr_a (ex_dm_addr),
    .rdata_a (dm_rdata),
    .raddr_b (dbg_mem_addr),
    .rdata_b (dbg_mem_val)
  );

  tiny16_regfile #(.DW(DW), .RAW(RAW)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (ex_reg_we & ~rst),
    .waddr     (ex_reg_waddr),
    .wdata     (ex_reg_wdata),
    .rd_a_addr (sel_a),
    .rd_a_data (a_data),
    .rd_b_addr (sel_b),
    .rd_b_data (b_data),
    .zero_data (zero_data),
    .dbg_addr  (dbg_reg_sel),
    .dbg_data  (dbg_reg_val)
  );

  tiny16_exec #(.DW(DW), .AW(AW), .RAW(RAW)) i_exec (
    .instr     (instr),
    .pc        (pc_q),
    .a_data    (a_data),
    .b_data    (b_data),
    .zero_data (zero_data),
    .dm_rdata  (dm_rdata),
    .op        (op),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .next_pc   (next_pc),
    .reg_we    (ex_reg_we),
    .reg_waddr (ex_reg_waddr),
    .reg_wdata (ex_reg_wdata),
    .dm_we     (ex_dm_we),
    .dm_addr   (ex_dm_addr),
    .dm_wdata  (ex_dm_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= next_pc;
    end
  end

  assign pc = pc_q;

  // ---------------- assertions ----------------
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_pc_reset_r1: assert (pc_q == '0)
        else $error("pc not zero after reset");
    end
  end

  // R3: a taken branch lands on pc + offset, wrapped
  p_br_target_r3: assert property (@(posedge clk) disable iff (rst)
    ((op == OPC_BR) && (zero_data == '0))
      |=> (pc_q == AW'($past(pc_q) + $past(instr[AW-1:0]))));

  // R2..R7: every other case steps the pc by one (incl. not-taken R3)
  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    !((op == OPC_BR) && (zero_data == '0))
      |=> (pc_q == AW'($past(pc_q) + AW'(1))));

endmodule

// File: tb/test_tiny16_cpu.sv
module test_tiny16_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [9:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic        data_we = 1'b0;
  logic [9:0]  data_addr = '0;
  logic [15:0] data_wdata = '0;
  logic [2:0]  dbg_reg_sel = '0;
  logic [15:0] dbg_reg_val;
  logic [9:0]  dbg_mem_addr = '0;
  logic [15:0] dbg_mem_val;
  logic [9:0]  pc;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  tiny16_cpu i_tiny16_cpu (
    .clk          (clk),
    .rst          (rst),
    .prog_we      (prog_we),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .data_we      (data_we),
    .data_addr    (data_addr),
    .data_wdata   (data_wdata),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_reg_val  (dbg_reg_val),
    .dbg_mem_addr (dbg_mem_addr),
    .dbg_mem_val  (dbg_mem_val),
    .pc           (pc)
  );

  // ---------- encoders ----------
  function automatic logic [15:0] i_add(input logic [2:0] a, b, c);
    return {3'b000, a, b, c, 4'b0000};
  endfunction
  function automatic logic [15:0] i_br(input logic [9:0] off);
    return {3'b001, 3'b000, off};
  endfunction
  function automatic logic [15:0] i_ld(input logic [2:0] a, input logic [9:0] ad);
    return {3'b010, a, ad};
  endfunction
  function automatic logic [15:0] i_st(input logic [2:0] a, input logic [9:0] ad);
    return {3'b011, a, ad};
  endfunction
  function automatic logic [15:0] i_set(input logic [2:0] a, input logic [9:0] k);
    return {3'b100, a, k};
  endfunction

  // ---------- helpers ----------
  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pload(input logic [9:0] a, input logic [15:0] w);
    prog_we = 1'b1; prog_addr = a; prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic dload(input logic [9:0] a, input logic [15:0] w);
    data_we = 1'b1; data_addr = a; data_wdata = w;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic step(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_reg(input logic [2:0] r, output logic [15:0] v);
    dbg_reg_sel = r;
    @(negedge clk);
    v = dbg_reg_val;
  endtask

  task automatic read_mem(input logic [9:0] a, output logic [15:0] v);
    dbg_mem_addr = a;
    @(negedge clk);
    v = dbg_mem_val;
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    logic [15:0] v;
    hold_reset();
    for (int i = 0; i < 7; i++) pload(10'(i), i_set(3'(i + 1), 10'(i + 'h21)));
    pload(10'd7, i_set(3'd0, 10'd5));
    step(8);
    read_reg(3'd3, v);
    chk("R6", "r3 before reset", v, 16'h0023);
    hold_reset();
    chk("R1", "pc in reset", {6'b0, pc}, 16'h0000);
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), v);
      chk("R1", $sformatf("r%0d in reset", r), v, 16'h0000);
    end
  endtask

  task automatic t_add_load();
    logic [15:0] v;
    hold_reset();
    dload(10'd5, 16'hFFFF);
    dload(10'd6, 16'h0002);
    pload(10'd0, i_ld(3'd1, 10'd5));
    pload(10'd1, i_ld(3'd2, 10'd6));
    pload(10'd2, i_add(3'd1, 3'd2, 3'd3));
    pload(10'd3, i_add(3'd2, 3'd2, 3'd4));
    pload(10'd4, i_set(3'd0, 10'd0));
    pload(10'd5, i_br(10'd0));
    step(8);
    read_reg(3'd1, v); chk("R4", "ld r1", v, 16'hFFFF);
    read_reg(3'd2, v); chk("R4", "ld r2", v, 16'h0002);
    read_reg(3'd3, v); chk("R2", "add wrap r3", v, 16'h0001);
    read_reg(3'd4, v); chk("R2", "add r4", v, 16'h0004);
    // R9: a new select does not show before the next edge
    dbg_reg_sel = 3'd1;
    #1;
    chk("R9", "debug latency hold", dbg_reg_val, 16'h0004);
    @(negedge clk);
    chk("R9", "debug after edge", dbg_reg_val, 16'hFFFF);
  endtask

  task automatic t_branch();
    hold_reset();
    pload(10'd0, i_set(3'd0, 10'd1));
    pload(10'd1, i_br(10'd5));
    pload(10'd2, i_set(3'd0, 10'd0));
    pload(10'd3, i_br(10'd1020));
    pload(10'd1023, i_br(10'd4));
    step(1); chk("R3", "pc after set", {6'b0, pc}, 16'd1);
    step(1); chk("R3", "not taken", {6'b0, pc}, 16'd2);
    step(1); chk("R3", "pc after clear", {6'b0, pc}, 16'd3);
    step(1); chk("R3", "taken forward", {6'b0, pc}, 16'd1023);
    step(1); chk("R3", "taken wrap", {6'b0, pc}, 16'd3);
    pload(10'd1023, 16'hA000);
  endtask

  task automatic t_store();
    logic [15:0] v;
    hold_reset();
    pload(10'd0, i_set(3'd2, 10'h1AB));
    pload(10'd1, i_st(3'd2, 10'd9));
    pload(10'd2, i_set(3'd3, 10'h02C));
    pload(10'd3, i_st(3'd3, 10'd1023));
    pload(10'd4, i_set(3'd0, 10'd0));
    pload(10'd5, i_br(10'd0));
    step(8);
    read_mem(10'd9, v);    chk("R5", "st addr 9", v, 16'h01AB);
    read_mem(10'd1023, v); chk("R5", "st addr 1023", v, 16'h002C);
  endtask

  task automatic t_set();
    logic [15:0] v;
    hold_reset();
    dload(10'd7, 16'hFFFF);
    pload(10'd0, i_ld(3'd6, 10'd7));
    pload(10'd1, i_set(3'd6, 10'h3FF));
    pload(10'd2, i_set(3'd0, 10'd0));
    pload(10'd3, i_br(10'd0));
    step(6);
    read_reg(3'd6, v); chk("R6", "set zero-extend", v, 16'h03FF);
  endtask

  task automatic t_nop();
    logic [15:0] v;
    hold_reset();
    dload(10'h3FF, 16'h1234);
    pload(10'd0, i_set(3'd1, 10'h011));
    pload(10'd1, 16'hBFFF);
    pload(10'd2, 16'hDFFF);
    pload(10'd3, 16'hFFFF);
    pload(10'd4, i_set(3'd0, 10'd0));
    pload(10'd5, i_br(10'd0));
    step(2); chk("R7", "pc after op101", {6'b0, pc}, 16'd2);
    step(1); chk("R7", "pc after op110", {6'b0, pc}, 16'd3);
    step(1); chk("R7", "pc after op111", {6'b0, pc}, 16'd4);
    step(3);
    read_reg(3'd7, v);    chk("R7", "r7 untouched", v, 16'h0000);
    read_reg(3'd1, v);    chk("R7", "r1 untouched", v, 16'h0011);
    read_mem(10'h3FF, v); chk("R7", "mem untouched", v, 16'h1234);
  endtask

  task automatic t_load_port();
    logic [15:0] v;
    hold_reset();
    dload(10'd20, 16'h0101);
    pload(10'd0, i_set(3'd0, 10'd0));
    pload(10'd1, i_br(10'd0));
    step(3);
    dload(10'd20, 16'hBEEF);
    read_mem(10'd20, v); chk("R8", "load port blocked", v, 16'h0101);
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // ---------- main ----------
  initial begin
    hold_reset();
    for (int a = 0; a < 1024; a++) pload(10'(a), 16'hA000);
    t_reset();
    t_add_load();
    t_branch();
    t_store();
    t_set();
    t_nop();
    t_load_port();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule